// File: doc/BRIEF.md
# CPU exception entry sequencer

This block performs the single-cycle state change a processor core makes when it enters an exception handler. Each cycle it looks at a pending synchronous exception (a valid strobe with a 4-bit cause code) and at level-sensitive timer and external interrupt requests. The timer and external requests are gated by enable bits in the current status word. When an entry is accepted, one clock edge loads every architectural register the entry touches:

- the saved program counter, adjusted for delay slots and for system-call and floating-point causes;
- the saved status word;
- the fault address register, for illegal instructions only;
- the new status word;
- the power-management bits;
- the load-link reservation.

At the same edge the block raises a one-cycle redirect strobe that carries the handler address.

The handler address is built from the cause code shifted left by eight bits. An optional vector base register is ORed in, and so is a fixed high-address prefix when the status word asks for it. A cause code outside the defined range stops the sequencer. It then raises a sticky fatal flag, redirects nowhere and accepts nothing more until reset. Decode, address translation, pipeline flushing and exception return are handled elsewhere. The core drives the current PC, status word, power-management word and delay-slot flag, and takes the registered outputs as its new state.

Top module: `exc_entry_seq`

## Requirements
- R1: Synchronous active-high reset clears every output register to zero, including the sticky fatal flag and both strobes.
- R2: An entry is accepted on a clock edge when exc_valid is high with a defined code (1 to 14). If exc_valid is low, a timer request is accepted as code 5 when status bit 1 is set. Otherwise an external request is accepted as code 8 when status bit 2 is set. The timer wins over the external request. In the cycle after the accepting edge, redirect_q is high and code_q holds the accepted code.
- R3: On entry, esr_q receives the pre-entry status word, and epc_q receives the current PC unless R7 or R8 adjusts it.
- R4: eear_q is loaded with the current PC only for code 7 (illegal instruction). Every other entry leaves it unchanged.
- R5: The new status word sr_q is the old one with bits 1, 2, 5 and 6 cleared (timer enable, interrupt enable, data and instruction translation enable) and bit 0 (supervisor) set.
- R6: On entry, pm_q receives the current power-management word with bits 4 (doze enable) and 5 (sleep enable) cleared, and resv_q becomes all ones.
- R7: When in_dslot is high at entry, epc_q is the current PC minus 4, status bit 13 is set in sr_q, and dslot_clr_q pulses for one cycle together with redirect_q.
- R8: When in_dslot is low at entry, status bit 13 is cleared in sr_q. For codes 12 (system call) and 13 (floating point) only, epc_q is the current PC plus 4.
- R9: redirect_pc_q is the code shifted left by 8, ORed with vec_base when vbase_en is set, and ORed with 0xF000_0000 when status bit 14 is set.
- R10: An interrupt request whose enable bit is clear is ignored. So is a cycle with no request. In both cases no redirect is raised and all saved registers hold their values.
- R11: exc_valid with code 0 or 15 sets fatal_q, which stays set until reset. It raises no redirect and updates no saved register. While fatal_q is set, every request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | 4 | Cause code of the pending exception |
| irq_tick | input | 1 | Timer interrupt request (level) |
| irq_ext | input | 1 | External interrupt request (level) |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| cur_pm | input | 32 | Current power-management word |
| in_dslot | input | 1 | Faulting instruction is in a delay slot |
| vec_base | input | 32 | Vector base register |
| vbase_en | input | 1 | Configuration flag enabling the vector base |
| epc_q | output | 32 | Saved program counter |
| esr_q | output | 32 | Saved status word |
| eear_q | output | 32 | Fault effective address |
| sr_q | output | 32 | New status word |
| pm_q | output | 32 | New power-management word |
| resv_q | output | 32 | Load-link reservation address |
| code_q | output | 4 | Code of the last accepted entry |
| redirect_q | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_q | output | 32 | Handler address |
| dslot_clr_q | output | 1 | One-cycle delay-slot flag clear strobe |
| fatal_q | output | 1 | Sticky unhandled-code flag |

## Verification
The main function is tried with a plain synchronous cause (alignment), an illegal instruction, and a page fault taken in a delay slot. Comparing these separates the fault address update and the minus-four adjustment from the plain case. A system call outside a delay slot and a floating-point fault inside one show which of the two PC adjustments wins. A trap with both vector base and high prefix enabled, and an all-ones power-management word, show that each OR term and each cleared bit acts on its own. Interrupt patterns cover both requests with both enables set (timer priority), each request alone, and both with enables clear (ignored). An undefined code followed by valid requests shows that the stop persists until reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] exc_code_t;

  localparam exc_code_t EXC_TICK    = 4'd5;
  localparam exc_code_t EXC_ILLEGAL = 4'd7;
  localparam exc_code_t EXC_EXTINT  = 4'd8;
  localparam exc_code_t EXC_SYSCALL = 4'd12;
  localparam exc_code_t EXC_FPE     = 4'd13;
  localparam exc_code_t EXC_LAST    = 4'd14;

  // status word bit positions
  localparam int SR_SUPV  = 0;
  localparam int SR_TICKE = 1;
  localparam int SR_INTE  = 2;
  localparam int SR_DXLAT = 5;
  localparam int SR_IXLAT = 6;
  localparam int SR_DSLOT = 13;
  localparam int SR_HIVEC = 14;

  // power-management bit positions
  localparam int PM_DOZE  = 4;
  localparam int PM_SLEEP = 5;

  typedef struct packed {
    logic      take;
    logic      bad;
    exc_code_t code;
  } entry_sel_t;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
(
  input  logic       halted,
  input  logic       exc_valid,
  input  exc_code_t  exc_code,
  input  logic       irq_tick,
  input  logic       irq_ext,
  input  logic       tick_en,
  input  logic       ext_en,
  output entry_sel_t sel
);
  always_comb begin
    sel = '0;
    if (!halted) begin
      if (exc_valid) begin
        sel.code = exc_code;
        if (exc_code == '0 || exc_code > EXC_LAST) sel.bad = 1'b1;
        else                                       sel.take = 1'b1;
      end else if (irq_tick && tick_en) begin
        sel.take = 1'b1;
        sel.code = EXC_TICK;
      end else if (irq_ext && ext_en) begin
        sel.take = 1'b1;
        sel.code = EXC_EXTINT;
      end
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_PREFIX = 32'hF000_0000
) (
  input  exc_code_t       code,
  input  logic [XLEN-1:0] vec_base,
  input  logic            vbase_en,
  input  logic            hi_sel,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base_part;
  logic [XLEN-1:0] hi_part;

  assign base_part = vbase_en ? vec_base  : '0;
  assign hi_part   = hi_sel   ? HI_PREFIX : '0;
  assign target    = ((XLEN)'(code) << VEC_SHIFT) | base_part | hi_part;
endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int INSN_SZ = 4
) (
  input  exc_code_t       code,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] sr,
  input  logic [XLEN-1:0] pm,
  input  logic            dslot,
  output logic [XLEN-1:0] epc_n,
  output logic [XLEN-1:0] sr_n,
  output logic [XLEN-1:0] pm_n
);
  localparam logic [XLEN-1:0] STEP = (XLEN)'(INSN_SZ);
  logic past_insn;

  assign past_insn = (code == EXC_SYSCALL) || (code == EXC_FPE);

  always_comb begin
    if (dslot)          epc_n = pc - STEP;
    else if (past_insn) epc_n = pc + STEP;
    else                epc_n = pc;
  end

  always_comb begin
    sr_n = sr;
    sr_n[SR_DXLAT] = 1'b0;
    sr_n[SR_IXLAT] = 1'b0;
    sr_n[SR_INTE]  = 1'b0;
    sr_n[SR_TICKE] = 1'b0;
    sr_n[SR_SUPV]  = 1'b1;
    sr_n[SR_DSLOT] = dslot;
  end

  always_comb begin
    pm_n = pm;
    pm_n[PM_DOZE]  = 1'b0;
    pm_n[PM_SLEEP] = 1'b0;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              VEC_SHIFT = 8,
  parameter int              INSN_SZ   = 4,
  parameter logic [XLEN-1:0] HI_PREFIX = 32'hF000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_valid,
  input  logic [3:0]      exc_code,
  input  logic            irq_tick,
  input  logic            irq_ext,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_pm,
  input  logic            in_dslot,
  input  logic [XLEN-1:0] vec_base,
  input  logic            vbase_en,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] esr_q,
  output logic [XLEN-1:0] eear_q,
  output logic [XLEN-1:0] sr_q,
  output logic [XLEN-1:0] pm_q,
  output logic [XLEN-1:0] resv_q,
  output logic [3:0]      code_q,
  output logic            redirect_q,
  output logic [XLEN-1:0] redirect_pc_q,
  output logic            dslot_clr_q,
  output logic            fatal_q
);
  entry_sel_t      sel;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] epc_n, sr_n, pm_n;

  exc_select u_sel (
    .halted   (fatal_q),
    .exc_valid(exc_valid),
    .exc_code (exc_code),
    .irq_tick (irq_tick),
    .irq_ext  (irq_ext),
    .tick_en  (cur_sr[SR_TICKE]),
    .ext_en   (cur_sr[SR_INTE]),
    .sel      (sel)
  );

  exc_vector #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .HI_PREFIX(HI_PREFIX)) u_vec (
    .code    (sel.code),
    .vec_base(vec_base),
    .vbase_en(vbase_en),
    .hi_sel  (cur_sr[SR_HIVEC]),
    .target  (target)
  );

  exc_frame #(.XLEN(XLEN), .INSN_SZ(INSN_SZ)) u_frame (
    .code (sel.code),
    .pc   (cur_pc),
    .sr   (cur_sr),
    .pm   (cur_pm),
    .dslot(in_dslot),
    .epc_n(epc_n),
    .sr_n (sr_n),
    .pm_n (pm_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q         <= '0;
      esr_q         <= '0;
      eear_q        <= '0;
      sr_q          <= '0;
      pm_q          <= '0;
      resv_q        <= '0;
      code_q        <= '0;
      redirect_q    <= 1'b0;
      redirect_pc_q <= '0;
      dslot_clr_q   <= 1'b0;
      fatal_q       <= 1'b0;
    end else begin
      redirect_q  <= sel.take;
      dslot_clr_q <= sel.take && in_dslot;
      if (sel.bad) fatal_q <= 1'b1;
      if (sel.take) begin
        epc_q         <= epc_n;
        esr_q         <= cur_sr;
        sr_q          <= sr_n;
        pm_q          <= pm_n;
        resv_q        <= '1;
        code_q        <= sel.code;
        redirect_pc_q <= target;
        if (sel.code == EXC_ILLEGAL) eear_q <= cur_pc;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_valid,
  input logic            irq_tick,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] esr_q,
  input logic [XLEN-1:0] sr_q,
  input logic [XLEN-1:0] resv_q,
  input logic [3:0]      code_q,
  input logic            redirect_q,
  input logic            dslot_clr_q,
  input logic            fatal_q
);
  assert_tick_first_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_tick && cur_sr[SR_TICKE] && !exc_valid && !fatal_q) |=> (redirect_q && code_q == EXC_TICK));

  assert_esr_copy_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_tick && cur_sr[SR_TICKE] && !exc_valid && !fatal_q) |=> (esr_q == $past(cur_sr)));

  assert_new_sr_R5: assert property (@(posedge clk) disable iff (rst)
    redirect_q |-> (sr_q[SR_SUPV] && !sr_q[SR_TICKE] && !sr_q[SR_INTE]
                    && !sr_q[SR_DXLAT] && !sr_q[SR_IXLAT]));

  assert_resv_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_q |-> (resv_q == '1));

  assert_dslot_R7: assert property (@(posedge clk) disable iff (rst)
    dslot_clr_q |-> (redirect_q && sr_q[SR_DSLOT]));

  assert_fatal_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);

  assert_fatal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> !redirect_q);
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exc_valid  (exc_valid),
  .irq_tick   (irq_tick),
  .cur_sr     (cur_sr),
  .esr_q      (esr_q),
  .sr_q       (sr_q),
  .resv_q     (resv_q),
  .code_q     (code_q),
  .redirect_q (redirect_q),
  .dslot_clr_q(dslot_clr_q),
  .fatal_q    (fatal_q)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        irq_tick = 1'b0, irq_ext = 1'b0;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_pm = '0, vec_base = '0;
  logic        in_dslot = 1'b0, vbase_en = 1'b0;
  logic [31:0] epc_q, esr_q, eear_q, sr_q, pm_q, resv_q, redirect_pc_q;
  logic [3:0]  code_q;
  logic        redirect_q, dslot_clr_q, fatal_q;

  always #2 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_tick(irq_tick), .irq_ext(irq_ext), .cur_pc(cur_pc), .cur_sr(cur_sr),
    .cur_pm(cur_pm), .in_dslot(in_dslot), .vec_base(vec_base), .vbase_en(vbase_en),
    .epc_q(epc_q), .esr_q(esr_q), .eear_q(eear_q), .sr_q(sr_q), .pm_q(pm_q),
    .resv_q(resv_q), .code_q(code_q), .redirect_q(redirect_q),
    .redirect_pc_q(redirect_pc_q), .dslot_clr_q(dslot_clr_q), .fatal_q(fatal_q)
  );

  typedef struct {
    string       req;
    logic [31:0] epc, esr, eear, sr, pm, resv, tgt;
    logic [3:0]  code;
    logic        redir, dclr, fatal;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int   errors = 0, checks = 0;
  bit   done = 0;

  task automatic chk(input string req, input string fld, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, fld, act, exp);
    end
  endtask

  task automatic model_reset();
    m = '{req:"", epc:0, esr:0, eear:0, sr:0, pm:0, resv:0, tgt:0, code:0, redir:0, dclr:0, fatal:0};
  endtask

  // driver: computes the expected result of the current inputs and advances one cycle
  task automatic step(input string req);
    logic       take;
    logic [3:0] c;
    logic [31:0] ns;
    take = 0; c = 0;
    if (!m.fatal) begin
      if (exc_valid) begin
        if (exc_code == 0 || exc_code == 15) m.fatal = 1;
        else begin take = 1; c = exc_code; end
      end else if (irq_tick && cur_sr[1]) begin take = 1; c = 4'd5; end
      else if (irq_ext && cur_sr[2]) begin take = 1; c = 4'd8; end
    end
    m.redir = take;
    m.dclr  = take && in_dslot;
    if (take) begin
      m.esr = cur_sr;
      if (in_dslot) m.epc = cur_pc - 4;
      else if (c == 12 || c == 13) m.epc = cur_pc + 4;
      else m.epc = cur_pc;
      if (c == 7) m.eear = cur_pc;
      ns = cur_sr & ~32'h0000_0066;
      ns = (ns | 32'h1) & ~32'h0000_2000;
      if (in_dslot) ns = ns | 32'h0000_2000;
      m.sr   = ns;
      m.pm   = cur_pm & ~32'h30;
      m.resv = '1;
      m.code = c;
      m.tgt  = ({28'h0, c} << 8) | (vbase_en ? vec_base : 32'h0) | (cur_sr[14] ? 32'hF000_0000 : 32'h0);
    end
    m.req = req;
    q.push_back(m);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "redirect", {31'h0, redirect_q}, {31'h0, e.redir});
      chk(e.req, "dslot_clr", {31'h0, dslot_clr_q}, {31'h0, e.dclr});
      chk(e.req, "fatal", {31'h0, fatal_q}, {31'h0, e.fatal});
      chk(e.req, "epc", epc_q, e.epc);
      chk(e.req, "esr", esr_q, e.esr);
      chk(e.req, "eear", eear_q, e.eear);
      chk(e.req, "sr", sr_q, e.sr);
      chk(e.req, "pm", pm_q, e.pm);
      chk(e.req, "resv", resv_q, e.resv);
      chk(e.req, "code", {28'h0, code_q}, {28'h0, e.code});
      chk(e.req, "target", redirect_pc_q, e.tgt);
    end
  end

  task automatic idle();
    exc_valid = 0; irq_tick = 0; irq_ext = 0; in_dslot = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    // R1: all outputs zero after reset
    chk("R1", "epc", epc_q, 0);
    chk("R1", "sr", sr_q, 0);
    chk("R1", "resv", resv_q, 0);
    chk("R1", "target", redirect_pc_q, 0);
    chk("R1", "flags", {29'h0, redirect_q, dslot_clr_q, fatal_q}, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    step("R10");                                   // idle, hold
    // R2 R3 R5: alignment fault
    cur_pc = 32'h1000; cur_sr = 32'h0000_0066; exc_valid = 1; exc_code = 4'd6;
    step("R2_R3_R5");
    // R4: illegal instruction loads eear
    cur_pc = 32'h2000; exc_code = 4'd7; cur_sr = 32'h0000_0A04;
    step("R4");
    // R7: page fault in a delay slot
    cur_pc = 32'h3000; exc_code = 4'd3; in_dslot = 1;
    step("R7");
    // R8: system call outside delay slot, stale DSX bit in status
    in_dslot = 0; cur_pc = 32'h4000; exc_code = 4'd12; cur_sr = 32'h0000_2006;
    step("R8");
    // R7: floating point in delay slot, minus four wins
    in_dslot = 1; cur_pc = 32'h5000; exc_code = 4'd13;
    step("R7_fpe");
    in_dslot = 0;
    // R9: base and high prefix
    vbase_en = 1; vec_base = 32'h0001_0000; cur_sr = 32'h0000_4000; exc_code = 4'd14; cur_pc = 32'h6000;
    step("R9");
    vbase_en = 0; cur_sr = 32'h0;
    step("R9_base_off");
    // R6: pm bits
    cur_pm = 32'hFFFF_FFFF; exc_code = 4'd2;
    step("R6");
    // R2: timer priority over external
    exc_valid = 0; irq_tick = 1; irq_ext = 1; cur_sr = 32'h0000_0006; cur_pc = 32'h7000;
    step("R2_prio");
    irq_tick = 0;
    step("R2_ext");
    // R10: gated requests ignored
    irq_tick = 1; irq_ext = 1; cur_sr = 32'h0000_0000; cur_pc = 32'h8000;
    step("R10");
    irq_tick = 0; irq_ext = 0;
    // R11: undefined codes
    exc_valid = 1; exc_code = 4'd0;
    step("R11");
    exc_code = 4'd4;
    step("R11_halt");
    exc_valid = 0; irq_tick = 1; cur_sr = 32'h0000_0002;
    step("R11_halt_irq");
    idle();
    step("R11_hold");
    @(negedge clk);
    do_reset();
    exc_valid = 1; exc_code = 4'd15; cur_sr = 32'h0;
    step("R11_15");
    idle();
    @(negedge clk);
    do_reset();
    exc_valid = 1; exc_code = 4'd2; cur_pc = 32'h9000; cur_sr = 32'h0000_0004;
    step("R1_recover");
    idle();
    step("R10_after");
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule